// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block paints a small bitmap cursor over a stream of background pixels. Each clock it receives one background pixel together with that pixel's x and y coordinates. When the coordinate falls inside the cursor square, it replaces the pixel with a colour taken from the cursor bitmap. Outside the square, or wherever the cursor is off, the background passes through unchanged. The composited pixel appears one clock after its inputs.

The bitmap is held in a local store of 32-bit words, which software fills through a simple write port. A 3-bit mode selects one of six layouts: the side of the square (32, 64 or 128), the depth (2 or 1 bits per pixel), and whether the highest code is transparent. A code indexes a set of four 24-bit colour inputs. The position word sets the cursor location. Two tip offsets shift the square up and to the left of that location, so any point inside the bitmap can be used as the hot spot. The block also reports the number of bitmap words in one cursor line, in the form a line-control register expects.

Top module: `hw_cursor_overlay`

## Requirements
- R1: Mode 0 draws a 32x32 cursor at 2 bits per pixel, and all four codes 0..3 select colour0..colour3.
- R2: Mode 1 is mode 0 with code 3 made transparent: where the bitmap holds code 3, the background pixel is output.
- R3: Mode 2 draws a 64x64 cursor at 2 bits per pixel with four colours. Mode 3 is the same with code 3 transparent.
- R4: Mode 4 draws a 128x128 cursor at 1 bit per pixel, where code 0 selects colour0 and code 1 selects colour1. Mode 5 is the same except that code 1 is transparent.
- R5: The mode is read from ctrl_word[2:0], the horizontal tip offset tipX from ctrl_word[13:8] and the vertical tip offset tipY from ctrl_word[21:16]. All other control bits are ignored.
- R6: pos_word[15:0] is the cursor X and pos_word[31:16] is the cursor Y. A pixel is covered only when X-tipX <= pix_x < X-tipX+side and Y-tipY <= pix_y < Y-tipY+side, with signed arithmetic. A square that extends past coordinate 0 is clipped, not wrapped.
- R7: Within a cursor line, pixel k occupies bit offset k*bpp counted from bit 31 of word (row*wpl + k*bpp/32). Here row is the line within the cursor and wpl = bpp*side/32, so each word is read MSB first.
- R8: line_ctrl carries wpl in both [15:0] and [31:16]. This value is 2 for modes 0 and 1, 4 for modes 2 to 5, and 0 for the reserved modes 6 and 7.
- R9: When cursor_en is low, or the mode is 6 or 7, pix_out equals the background pixel.
- R10: pix_out is registered. It reflects the inputs of the previous clock and is zero while rst is high.
- R11: While bm_we is high, bm_wdata is stored at word bm_waddr on the rising clock edge, and later pixels read the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cursor_en | input | 1 | Cursor enable |
| ctrl_word | input | 32 | Mode [2:0], tipX [13:8], tipY [21:16] |
| pos_word | input | 32 | Cursor X [15:0], cursor Y [31:16] |
| color0 | input | 24 | Colour for code 0, 0x00RRGGBB |
| color1 | input | 24 | Colour for code 1 |
| color2 | input | 24 | Colour for code 2 |
| color3 | input | 24 | Colour for code 3 |
| bm_we | input | 1 | Bitmap store write enable |
| bm_waddr | input | 9 | Bitmap store word address |
| bm_wdata | input | 32 | Bitmap store write data |
| pix_x | input | 16 | Background pixel x |
| pix_y | input | 16 | Background pixel y |
| bg_pix | input | 24 | Background pixel colour |
| pix_out | output | 24 | Composited pixel, one clock later |
| line_ctrl | output | 32 | Words per cursor line in both halves |

## Verification
The bench sweeps every pixel of each mode's square plus a border around it, so an off-by-one at either window edge shows up as a cursor one pixel wide or short. Each mode uses a different line stride and packing. A wrong words-per-line value would shear the image from row 1 onward, and LSB-first packing would mirror each word. The transparent modes must pass the background only for the top code; a design that treats the wrong code as transparent would erase one colour. A square placed so it overlaps coordinate 0 checks that negative starts are clipped and not wrapped to high coordinates. An enable-off pass and the reserved modes check that the background passes through unchanged.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    localparam int WORD_W      = 32;
    localparam int SEL_W       = $clog2(WORD_W);
    localparam int MAX_SIDE    = 128;
    localparam int IDX_W       = $clog2(MAX_SIDE);
    localparam int SIDE_W      = IDX_W + 1;
    localparam int STORE_WORDS = MAX_SIDE * MAX_SIDE / WORD_W;
    localparam int STORE_AW    = $clog2(STORE_WORDS);
    localparam int WPL_W       = 3;
    localparam int TIP_W       = 6;
    localparam int COORD_W     = 16;
    localparam int COLOR_W     = 24;
    localparam int N_COLORS    = 4;

    typedef enum logic [2:0] {
        HWC_S32_FULL  = 3'd0,
        HWC_S32_CLEAR = 3'd1,
        HWC_S64_FULL  = 3'd2,
        HWC_S64_CLEAR = 3'd3,
        HWC_S128_FULL = 3'd4,
        HWC_S128_CLEAR= 3'd5,
        HWC_RSV_A     = 3'd6,
        HWC_RSV_B     = 3'd7
    } hwc_mode_e;

    typedef struct packed {
        logic              valid;
        logic [SIDE_W-1:0] side;
        logic              two_bpp;
        logic              transp;
        logic [WPL_W-1:0]  wpl;
    } hwc_geom_t;

    typedef struct packed {
        logic [TIP_W-1:0] tip_y;
        logic [TIP_W-1:0] tip_x;
        hwc_mode_e        mode;
    } hwc_ctrl_t;

    function automatic hwc_geom_t decode_mode(input hwc_mode_e m);
        hwc_geom_t       g;
        logic [SIDE_W+1:0] line_bits;
        g = '0;
        case (m)
            HWC_S32_FULL:   begin g.valid = 1'b1; g.side = SIDE_W'(32);  g.two_bpp = 1'b1; end
            HWC_S32_CLEAR:  begin g.valid = 1'b1; g.side = SIDE_W'(32);  g.two_bpp = 1'b1; g.transp = 1'b1; end
            HWC_S64_FULL:   begin g.valid = 1'b1; g.side = SIDE_W'(64);  g.two_bpp = 1'b1; end
            HWC_S64_CLEAR:  begin g.valid = 1'b1; g.side = SIDE_W'(64);  g.two_bpp = 1'b1; g.transp = 1'b1; end
            HWC_S128_FULL:  begin g.valid = 1'b1; g.side = SIDE_W'(128); end
            HWC_S128_CLEAR: begin g.valid = 1'b1; g.side = SIDE_W'(128); g.transp = 1'b1; end
            default:        g = '0;
        endcase
        line_bits = g.two_bpp ? {1'b0, g.side, 1'b0} : {2'b00, g.side};
        g.wpl     = line_bits[SEL_W+WPL_W-1:SEL_W];
        return g;
    endfunction

    function automatic hwc_ctrl_t unpack_ctrl(input logic [31:0] w);
        hwc_ctrl_t c;
        c.mode  = hwc_mode_e'(w[2:0]);
        c.tip_x = w[8+TIP_W-1:8];
        c.tip_y = w[16+TIP_W-1:16];
        return c;
    endfunction

endpackage

// File: rtl/hwc_bitmap_store.sv
module hwc_bitmap_store
    import hwc_pkg::*;
#(
    parameter int DEPTH = STORE_WORDS,
    parameter int AW    = STORE_AW,
    parameter int DW    = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    AST_STORE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data)) else $error("store write lost"); // R11

endmodule

// File: rtl/hwc_locator.sv
module hwc_locator
    import hwc_pkg::*;
#(
    parameter int CW = COORD_W,
    parameter int AW = STORE_AW
) (
    input  hwc_geom_t        geom,
    input  logic [TIP_W-1:0] tip_x,
    input  logic [TIP_W-1:0] tip_y,
    input  logic [CW-1:0]    pos_x,
    input  logic [CW-1:0]    pos_y,
    input  logic [CW-1:0]    pix_x,
    input  logic [CW-1:0]    pix_y,
    output logic             hit,
    output logic [AW-1:0]    rd_addr,
    output logic [SEL_W-1:0] bit_sel
);

    localparam int DW_ = CW + 2;
    localparam int COL_W = IDX_W + 1 - SEL_W;

    logic signed [DW_-1:0] dx, dy, side_s;
    logic                  in_x, in_y;
    logic [IDX_W-1:0]      dxi, dyi;
    logic [IDX_W:0]        bit_off;
    logic [COL_W-1:0]      col;
    logic [AW-1:0]         row_base;

    // offsets of the pixel from the top-left corner of the cursor square
    always_comb begin
        dx = $signed({2'b00, pix_x}) - $signed({2'b00, pos_x})
           + $signed({{(DW_-TIP_W){1'b0}}, tip_x});
        dy = $signed({2'b00, pix_y}) - $signed({2'b00, pos_y})
           + $signed({{(DW_-TIP_W){1'b0}}, tip_y});
        side_s = $signed({{(DW_-SIDE_W){1'b0}}, geom.side});
        in_x = (dx >= 0) && (dx < side_s);
        in_y = (dy >= 0) && (dy < side_s);
        hit  = geom.valid && in_x && in_y;
    end

    assign dxi = dx[IDX_W-1:0];
    assign dyi = dy[IDX_W-1:0];

    // bit position inside the line, then word column and bit inside the word
    assign bit_off  = geom.two_bpp ? {dxi, 1'b0} : {1'b0, dxi};
    assign col      = bit_off[IDX_W:SEL_W];
    assign bit_sel  = bit_off[SEL_W-1:0];
    assign row_base = {{(AW-IDX_W){1'b0}}, dyi} * {{(AW-WPL_W){1'b0}}, geom.wpl};
    assign rd_addr  = row_base + {{(AW-COL_W){1'b0}}, col};

endmodule

// File: rtl/hwc_compose.sv
module hwc_compose
    import hwc_pkg::*;
#(
    parameter int CLW = COLOR_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  hwc_geom_t                    geom,
    input  logic                         hit,
    input  logic [WORD_W-1:0]            word,
    input  logic [SEL_W-1:0]             bit_sel,
    input  logic [N_COLORS-1:0][CLW-1:0] palette,
    input  logic [CLW-1:0]               bg_pix,
    output logic [CLW-1:0]               pix_out
);

    logic [SEL_W-1:0] hi_idx, lo_idx;
    logic [1:0]       code, top_code;
    logic             clear, draw;
    logic [CLW-1:0]   next_pix;

    // MSB-first: the first pixel of a word sits in its top bits
    assign hi_idx   = SEL_W'(WORD_W - 1) - bit_sel;
    assign lo_idx   = SEL_W'(WORD_W - 2) - bit_sel;
    assign code     = geom.two_bpp ? {word[hi_idx], word[lo_idx]} : {1'b0, word[hi_idx]};
    assign top_code = geom.two_bpp ? 2'd3 : 2'd1;
    assign clear    = geom.transp && (code == top_code);
    assign draw     = en && hit && !clear;
    assign next_pix = draw ? palette[code] : bg_pix;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out <= '0;
        end else begin
            pix_out <= next_pix;
        end
    end

    AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (rst)
        (en && hit && geom.transp && code == top_code) |=> pix_out == $past(bg_pix))
        else $error("transparent code drew"); // R2

endmodule

// File: rtl/hw_cursor_overlay.sv
module hw_cursor_overlay
    import hwc_pkg::*;
#(
    parameter int CLW = COLOR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cursor_en,
    input  logic [31:0]         ctrl_word,
    input  logic [31:0]         pos_word,
    input  logic [CLW-1:0]      color0,
    input  logic [CLW-1:0]      color1,
    input  logic [CLW-1:0]      color2,
    input  logic [CLW-1:0]      color3,
    input  logic                bm_we,
    input  logic [STORE_AW-1:0] bm_waddr,
    input  logic [WORD_W-1:0]   bm_wdata,
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic [CLW-1:0]      bg_pix,
    output logic [CLW-1:0]      pix_out,
    output logic [31:0]         line_ctrl
);

    localparam int HALF_W = 16;

    hwc_ctrl_t                    ctrl;
    hwc_geom_t                    geom;
    logic                         hit;
    logic [STORE_AW-1:0]          rd_addr;
    logic [SEL_W-1:0]             bit_sel;
    logic [WORD_W-1:0]            rd_word;
    logic [N_COLORS-1:0][CLW-1:0] palette;
    logic                         unused_ctrl_bits;

    assign ctrl = unpack_ctrl(ctrl_word);
    assign geom = decode_mode(ctrl.mode);
    assign unused_ctrl_bits = ^{ctrl_word[31:22], ctrl_word[15:14], ctrl_word[7:3]};

    assign palette = {color3, color2, color1, color0};

    for (genvar h = 0; h < 2; h++) begin : g_line_half
        assign line_ctrl[h*HALF_W +: HALF_W] = {{(HALF_W-WPL_W){1'b0}}, geom.wpl};
    end

    hwc_locator #(.CW(COORD_W), .AW(STORE_AW)) u_loc (
        .geom    (geom),
        .tip_x   (ctrl.tip_x),
        .tip_y   (ctrl.tip_y),
        .pos_x   (pos_word[COORD_W-1:0]),
        .pos_y   (pos_word[31:32-COORD_W]),
        .pix_x   (pix_x),
        .pix_y   (pix_y),
        .hit     (hit),
        .rd_addr (rd_addr),
        .bit_sel (bit_sel)
    );

    hwc_bitmap_store #(.DEPTH(STORE_WORDS), .AW(STORE_AW), .DW(WORD_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bm_we),
        .wr_addr (bm_waddr),
        .wr_data (bm_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    hwc_compose #(.CLW(CLW)) u_comp (
        .clk     (clk),
        .rst     (rst),
        .en      (cursor_en),
        .geom    (geom),
        .hit     (hit),
        .word    (rd_word),
        .bit_sel (bit_sel),
        .palette (palette),
        .bg_pix  (bg_pix),
        .pix_out (pix_out)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> pix_out == '0) else $error("output not cleared"); // R10

    AST_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
        !cursor_en |=> pix_out == $past(bg_pix)) else $error("disabled cursor drew"); // R9

    AST_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
        !hit |=> pix_out == $past(bg_pix)) else $error("pixel outside square altered"); // R6

endmodule

// File: tb/tb_hw_cursor_overlay.sv
module tb_hw_cursor_overlay;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cursor_en = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] pos_word = '0;
    logic [23:0] color0 = 24'hFF0000;
    logic [23:0] color1 = 24'h00FF00;
    logic [23:0] color2 = 24'h0000FF;
    logic [23:0] color3 = 24'hFFFF00;
    logic        bm_we = 1'b0;
    logic [8:0]  bm_waddr = '0;
    logic [31:0] bm_wdata = '0;
    logic [15:0] pix_x = '0;
    logic [15:0] pix_y = '0;
    logic [23:0] bg_pix = '0;
    logic [23:0] pix_out;
    logic [31:0] line_ctrl;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] img [512];
    int m_mode, m_en, m_px, m_py, m_tx, m_ty;

    always #10 clk = ~clk;

    hw_cursor_overlay dut (
        .clk(clk), .rst(rst), .cursor_en(cursor_en), .ctrl_word(ctrl_word),
        .pos_word(pos_word), .color0(color0), .color1(color1), .color2(color2),
        .color3(color3), .bm_we(bm_we), .bm_waddr(bm_waddr), .bm_wdata(bm_wdata),
        .pix_x(pix_x), .pix_y(pix_y), .bg_pix(bg_pix), .pix_out(pix_out),
        .line_ctrl(line_ctrl)
    );

    function automatic logic [31:0] pattern(input int a);
        logic [31:0] v;
        v = 32'(a) * 32'h9E3779B1;
        return v ^ (32'(a) << 13) ^ 32'h0F1E2D3C;
    endfunction

    function automatic logic [23:0] bg_of(input int x, input int y);
        return {x[7:0], y[7:0], 8'h5A};
    endfunction

    function automatic logic [23:0] model(input int x, input int y);
        int side, bpp, tr, dx, dy, wpl, bpos, addr, code;
        logic [31:0] w;
        logic [23:0] pal [4];
        pal[0] = color0; pal[1] = color1; pal[2] = color2; pal[3] = color3;
        case (m_mode)
            0: begin side = 32;  bpp = 2; tr = 0; end
            1: begin side = 32;  bpp = 2; tr = 1; end
            2: begin side = 64;  bpp = 2; tr = 0; end
            3: begin side = 64;  bpp = 2; tr = 1; end
            4: begin side = 128; bpp = 1; tr = 0; end
            5: begin side = 128; bpp = 1; tr = 1; end
            default: return bg_of(x, y);
        endcase
        if (m_en == 0) return bg_of(x, y);
        dx = x - (m_px - m_tx);
        dy = y - (m_py - m_ty);
        if (dx < 0 || dx >= side || dy < 0 || dy >= side) return bg_of(x, y);
        wpl  = bpp * side / 32;
        bpos = dx * bpp;
        addr = dy * wpl + bpos / 32;
        w    = img[addr];
        code = int'((w >> (32 - bpp - (bpos % 32))) & ((1 << bpp) - 1));
        if (tr != 0 && code == (1 << bpp) - 1) return bg_of(x, y);
        return pal[code];
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic setup(input int mode, input int en, input int px, input int py,
                         input int tx, input int ty);
        m_mode = mode; m_en = en; m_px = px; m_py = py; m_tx = tx; m_ty = ty;
        @(negedge clk);
        cursor_en = (en != 0);
        ctrl_word = {10'h2A5, ty[5:0], 2'b11, tx[5:0], 5'b10101, mode[2:0]};
        pos_word  = {py[15:0], px[15:0]};
    endtask

    task automatic pix(input int x, input int y, input string tag);
        @(negedge clk);
        pix_x  = x[15:0];
        pix_y  = y[15:0];
        bg_pix = bg_of(x, y);
        @(posedge clk);
        #2;
        chk({8'h00, pix_out}, {8'h00, model(x, y)}, tag);
    endtask

    task automatic sweep(input int margin, input string tag);
        int side;
        side = (m_mode < 2) ? 32 : (m_mode < 4) ? 64 : 128;
        for (int y = m_py - m_ty - margin; y < m_py - m_ty + side + margin; y++) begin
            for (int x = m_px - m_tx - margin; x < m_px - m_tx + side + margin; x++) begin
                if (x >= 0 && y >= 0) pix(x, y, tag);
            end
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bm_we = 1'b1; bm_waddr = a[8:0]; bm_wdata = d;
        @(negedge clk);
        bm_we = 1'b0;
        img[a] = d;
    endtask

    task automatic line_check(input int mode, input int exp_wpl);
        setup(mode, 1, 40, 30, 0, 0);
        #1;
        chk(line_ctrl, {exp_wpl[15:0], exp_wpl[15:0]}, "R8 line_ctrl halves");
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_mode = 0; m_en = 0; m_px = 0; m_py = 0; m_tx = 0; m_ty = 0;
        repeat (3) @(posedge clk);
        #2;
        chk({8'h00, pix_out}, 32'h0, "R10 reset value");
        @(negedge clk);
        rst = 1'b0;

        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            bm_we = 1'b1; bm_waddr = a[8:0]; bm_wdata = pattern(a);
            img[a] = pattern(a);
        end
        @(negedge clk);
        bm_we = 1'b0;

        // R8 words per line for every mode code
        line_check(0, 2); line_check(1, 2); line_check(2, 4);
        line_check(3, 4); line_check(4, 4); line_check(5, 4);
        line_check(6, 0); line_check(7, 0);

        // main sweeps, tips exercise R5 field positions
        setup(0, 1, 50, 40, 5, 3);   sweep(3, "R1 R7 mode0 sweep");
        setup(1, 1, 50, 40, 7, 2);   sweep(3, "R2 mode1 sweep");
        setup(2, 1, 90, 80, 12, 9);  sweep(3, "R3 R7 mode2 sweep");
        setup(3, 1, 90, 80, 1, 30);  sweep(3, "R3 mode3 sweep");
        setup(4, 1, 150, 140, 20, 4); sweep(2, "R4 R7 mode4 sweep");
        setup(5, 1, 150, 140, 0, 63); sweep(2, "R4 mode5 sweep");
        setup(2, 1, 100, 100, 63, 0); sweep(1, "R5 tip field extremes");

        // R6 clipping past coordinate 0
        setup(0, 1, 2, 1, 10, 12);   sweep(4, "R6 clipped square");

        // R9 enable low and reserved modes
        setup(0, 0, 50, 40, 0, 0);   sweep(2, "R9 enable low");
        setup(6, 1, 50, 40, 0, 0);   sweep(0, "R9 reserved mode 6");
        setup(7, 1, 50, 40, 0, 0);   sweep(0, "R9 reserved mode 7");

        // R11 rewrite a word and see it on the next pixels
        wr(0, 32'hC0000000);
        setup(0, 1, 60, 60, 0, 0);
        pix(60, 60, "R11 new word code3");
        pix(61, 60, "R11 new word code0");
        setup(1, 1, 60, 60, 0, 0);
        pix(60, 60, "R11 R2 new word transparent");
        wr(0, pattern(0));
        pix(60, 60, "R11 restored word");

        // R10 one clock latency: output holds until the next edge
        setup(0, 1, 60, 60, 0, 0);
        pix(61, 60, "R10 first pixel");
        @(negedge clk);
        pix_x = 16'd10; pix_y = 16'd10; bg_pix = bg_of(10, 10);
        #1;
        chk({8'h00, pix_out}, {8'h00, model(61, 60)}, "R10 held before edge");
        @(posedge clk);
        #2;
        chk({8'h00, pix_out}, {8'h00, model(10, 10)}, "R10 updated after edge");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule